// File: doc/BRIEF.md
# Serial Port Host Register Interface

This block sits between a host register bus and a byte-wide serializer of a fixed eight-bit, one-stop-bit serial port. It holds a transmit FIFO and a receive FIFO, 16 entries each. It reports receive and transmit events through a write-one-to-clear status register, an enable mask and a master enable. All byte traffic goes through one data word. In that word, flag bits act as handshakes. Writing with the send flag queues a byte. Reading shows the receive head and its valid flag without removing the byte. Writing with the receive flag discards the head.

The serializer side uses plain byte streams. The transmit FIFO head goes out on a valid/ready pair. Received bytes arrive on a valid strobe that has no back-pressure. The serializer also reports whether its shift register is still sending, so that the busy bit covers the last byte on the line. The register port is a 2-bit word address with a write enable. Read data depends combinationally on the address.

Top module: `serial_host_port`

## Requirements
- R1: After reset the word addresses read as follows. Address 0 (data) reads 0x200: send flag bit 9 is 1 and receive flag bit 8 is 0. Address 1 (control), address 2 (event status) and address 3 (event enable) read 0. irqOut is 0.
- R2: A write to address 0 with bit 9 set queues bits [7:0] in the transmit FIFO. Queued bytes leave on txByte/txValid, in write order, one per cycle in which txReady is high.
- R3: Bit 9 of address 0 reads 1 exactly when the transmit FIFO has a free entry. A send write while the FIFO holds 16 bytes is dropped.
- R4: Writing address 2 clears each status bit written as 1 and leaves each bit written as 0 unchanged.
- R5: Bit 14 of address 1 reads 1 while the transmit FIFO is not empty or shifterBusy is high, and reads 0 otherwise.
- R6: irqOut is 1 exactly when host enable bit 13 of address 1 is 1 and some status bit at address 2 is 1 with the same bit of address 3 also 1.
- R7: A byte that arrives on rxValid while the receive FIFO holds 16 bytes is dropped, and overflow status bit 2 of address 2 is set.
- R8: Status bit 1 of address 2 is set in the cycle the transmit FIFO count drops from above 2 to 2 or fewer. A count that rises does not set it.
- R9: A byte stored in the receive FIFO sets status bit 0 of address 2. A read of address 0 shows bit 8 = 1 and the oldest byte in [7:0]. Reading does not remove the byte.
- R10: A write to address 0 with bit 8 set removes the oldest receive byte. The same write on an empty receive FIFO has no effect, and bytes received afterwards are stored normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 2 | Word address: 0 data, 1 control, 2 event status, 3 event enable |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Read data for regAddr |
| txByte | output | 8 | Byte offered to the serializer |
| txValid | output | 1 | Transmit FIFO not empty |
| txReady | input | 1 | Serializer takes txByte this cycle |
| shifterBusy | input | 1 | Serializer shift register still sending |
| rxByte | input | 8 | Byte from the serializer |
| rxValid | input | 1 | rxByte present this cycle |
| irqOut | output | 1 | Gated interrupt line |

## Verification
The hardest condition to reach from the ports is the almost-empty event. It is an edge: the transmit count must pass through exactly 3 to 2 while the status bit has just been cleared, and a rising count must be seen not to set it. The stimulus holds txReady low and fills five entries, then releases txReady for single cycles, one byte at a time, and reads the status after each release. Receive overflow is reached by streaming 17 bytes with no pop in between. The scoreboard then confirms that the 17th byte never shows up.

// File: rtl/serial_host_pkg.sv
package serial_host_pkg;
  localparam int BYTE_W = 8;
  localparam int REG_W  = 32;
  localparam int IRQ_W  = 3;

  localparam logic [1:0] ADDR_DATA = 2'd0;
  localparam logic [1:0] ADDR_CTRL = 2'd1;
  localparam logic [1:0] ADDR_STAT = 2'd2;
  localparam logic [1:0] ADDR_IEN  = 2'd3;

  localparam int DATA_RX_FLAG = 8;
  localparam int DATA_TX_FLAG = 9;
  localparam int CTRL_HOST_IE = 13;
  localparam int CTRL_TX_BUSY = 14;

  localparam int EV_RX_VALID = 0;
  localparam int EV_TX_LOW   = 1;
  localparam int EV_RX_OVF   = 2;

  typedef struct packed {
    logic              txPush;
    logic              rxPop;
    logic [BYTE_W-1:0] txData;
  } strobe_t;

  typedef struct packed {
    logic              txFull;
    logic              txEmpty;
    logic              rxFull;
    logic              rxEmpty;
    logic [BYTE_W-1:0] rxHead;
    logic              rxStored;
    logic              rxDropped;
    logic              txFellLow;
  } dpStat_t;
endpackage

// File: rtl/serial_fifo.sv
module serial_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] rdData,
  output logic             full,
  output logic             empty,
  output logic [CNT_W-1:0] count
);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic             doPush, doPop;

  assign full   = (count == FULL_CNT);
  assign empty  = (count == '0);
  assign doPush = push && !full;
  assign doPop  = pop && !empty;
  assign rdData = mem[rdPtr];

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == LAST_PTR) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= nextPtr(wrPtr);
      if (doPop)  rdPtr <= nextPtr(rdPtr);
      case ({doPush, doPop})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/serial_host_dp.sv
module serial_host_dp
  import serial_host_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int LOW_MARK   = 2,
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic              txReady,
  output logic [BYTE_W-1:0] txByte,
  output logic              txValid,
  input  logic [BYTE_W-1:0] rxByte,
  input  logic              rxValid,
  output dpStat_t           stat
);
  localparam logic [CNT_W:0] LOW_V = (CNT_W + 1)'(LOW_MARK);

  logic [CNT_W-1:0]  txCount, rxCount;
  logic              txFull, txEmpty, rxFull, rxEmpty;
  logic              txPushEff, txPopEff, rxPushEff;
  logic [BYTE_W-1:0] rxHeadRaw;
  logic [CNT_W:0]    txCountWide, txNextWide;
  logic              unusedRxCount;

  assign txPushEff = strobe.txPush && !txFull;
  assign txPopEff  = txReady && !txEmpty;
  assign rxPushEff = rxValid && !rxFull;
  assign txValid   = !txEmpty;
  assign unusedRxCount = ^rxCount;

  serial_fifo #(.WIDTH(BYTE_W), .DEPTH(FIFO_DEPTH)) txFifo (
    .clk(clk), .rstN(rstN),
    .push(strobe.txPush), .pop(txReady),
    .wrData(strobe.txData), .rdData(txByte),
    .full(txFull), .empty(txEmpty), .count(txCount)
  );

  serial_fifo #(.WIDTH(BYTE_W), .DEPTH(FIFO_DEPTH)) rxFifo (
    .clk(clk), .rstN(rstN),
    .push(rxValid), .pop(strobe.rxPop),
    .wrData(rxByte), .rdData(rxHeadRaw),
    .full(rxFull), .empty(rxEmpty), .count(rxCount)
  );

  always_comb begin
    txCountWide = {1'b0, txCount};
    txNextWide  = txCountWide
                + {{CNT_W{1'b0}}, txPushEff}
                - {{CNT_W{1'b0}}, txPopEff};
  end

  always_comb begin
    stat           = '0;
    stat.txFull    = txFull;
    stat.txEmpty   = txEmpty;
    stat.rxFull    = rxFull;
    stat.rxEmpty   = rxEmpty;
    stat.rxHead    = rxEmpty ? '0 : rxHeadRaw;
    stat.rxStored  = rxPushEff;
    stat.rxDropped = rxValid && rxFull;
    stat.txFellLow = (txCountWide > LOW_V) && (txNextWide <= LOW_V);
  end
endmodule

// File: rtl/serial_host_ctrl.sv
module serial_host_ctrl
  import serial_host_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       regAddr,
  input  logic             regWrEn,
  input  logic [REG_W-1:0] regWrData,
  output logic [REG_W-1:0] regRdData,
  input  logic             shifterBusy,
  input  dpStat_t          stat,
  output strobe_t          strobe,
  output logic             irqOut,
  output logic             hostIe,
  output logic [IRQ_W-1:0] irqStat
);
  logic [IRQ_W-1:0] irqEn;
  logic [IRQ_W-1:0] evSet;
  logic [IRQ_W-1:0] evClr;
  logic             wrData, wrCtrl, wrStat, wrIen;
  logic             txBusy;
  logic             unusedBits;

  assign unusedBits = ^{regWrData[REG_W-1:CTRL_HOST_IE+1],
                        regWrData[CTRL_HOST_IE-1:DATA_TX_FLAG+1],
                        stat.rxFull};

  assign wrData = regWrEn && (regAddr == ADDR_DATA);
  assign wrCtrl = regWrEn && (regAddr == ADDR_CTRL);
  assign wrStat = regWrEn && (regAddr == ADDR_STAT);
  assign wrIen  = regWrEn && (regAddr == ADDR_IEN);

  always_comb begin
    strobe        = '0;
    strobe.txPush = wrData && regWrData[DATA_TX_FLAG];
    strobe.rxPop  = wrData && regWrData[DATA_RX_FLAG];
    strobe.txData = regWrData[BYTE_W-1:0];
  end

  always_comb begin
    evSet              = '0;
    evSet[EV_RX_VALID] = stat.rxStored;
    evSet[EV_TX_LOW]   = stat.txFellLow;
    evSet[EV_RX_OVF]   = stat.rxDropped;
    evClr              = wrStat ? regWrData[IRQ_W-1:0] : '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hostIe  <= 1'b0;
      irqEn   <= '0;
      irqStat <= '0;
    end else begin
      if (wrCtrl) hostIe <= regWrData[CTRL_HOST_IE];
      if (wrIen)  irqEn  <= regWrData[IRQ_W-1:0];
      irqStat <= (irqStat & ~evClr) | evSet;
    end
  end

  assign txBusy = !stat.txEmpty || shifterBusy;
  assign irqOut = hostIe && |(irqStat & irqEn);

  always_comb begin
    regRdData = '0;
    case (regAddr)
      ADDR_DATA: begin
        regRdData[BYTE_W-1:0]  = stat.rxHead;
        regRdData[DATA_RX_FLAG] = !stat.rxEmpty;
        regRdData[DATA_TX_FLAG] = !stat.txFull;
      end
      ADDR_CTRL: begin
        regRdData[CTRL_HOST_IE] = hostIe;
        regRdData[CTRL_TX_BUSY] = txBusy;
      end
      ADDR_STAT: regRdData[IRQ_W-1:0] = irqStat;
      default:   regRdData[IRQ_W-1:0] = irqEn;
    endcase
  end
endmodule

// File: rtl/serial_host_port.sv
module serial_host_port
  import serial_host_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int LOW_MARK   = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [1:0]  regAddr,
  input  logic        regWrEn,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  output logic [7:0]  txByte,
  output logic        txValid,
  input  logic        txReady,
  input  logic        shifterBusy,
  input  logic [7:0]  rxByte,
  input  logic        rxValid,
  output logic        irqOut
);
  strobe_t          strobe;
  dpStat_t          dpStat;
  logic             hostIe;
  logic [IRQ_W-1:0] irqStat;

  serial_host_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .shifterBusy(shifterBusy),
    .stat(dpStat), .strobe(strobe), .irqOut(irqOut),
    .hostIe(hostIe), .irqStat(irqStat)
  );

  serial_host_dp #(.FIFO_DEPTH(FIFO_DEPTH), .LOW_MARK(LOW_MARK)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .txReady(txReady), .txByte(txByte), .txValid(txValid),
    .rxByte(rxByte), .rxValid(rxValid), .stat(dpStat)
  );
endmodule

// File: rtl/serial_host_chk.sv
module serial_host_chk (
  input logic        clk,
  input logic        rstN,
  input logic [1:0]  regAddr,
  input logic        regWrEn,
  input logic [31:0] regWrData,
  input logic [31:0] regRdData,
  input logic        txValid,
  input logic        rxValid,
  input logic        irqOut,
  input logic        hostIe,
  input logic [2:0]  irqStat,
  input logic        rxFull
);
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rstN)
    !hostIe |-> !irqOut); // R6

  AST_BUSY_WHILE_QUEUED: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && regAddr == 2'd1) |-> regRdData[14]); // R5

  AST_OVF_FLAGGED: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && rxFull) |=> irqStat[2]); // R7

  AST_RX_EVENT: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && !rxFull) |=> irqStat[0]); // R9

  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == 2'd2 && regWrData[0] && !rxValid) |=> !irqStat[0]); // R4

  AST_W1C_KEEPS: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == 2'd2 && !regWrData[2] && irqStat[2]) |=> irqStat[2]); // R4
endmodule

bind serial_host_port serial_host_chk u_chk (
  .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
  .regWrData(regWrData), .regRdData(regRdData), .txValid(txValid),
  .rxValid(rxValid), .irqOut(irqOut), .hostIe(hostIe),
  .irqStat(irqStat), .rxFull(dpStat.rxFull)
);

// File: tb/test_serial_host_port.sv
module test_serial_host_port;
  logic        clk = 0;
  logic        rstN = 0;
  logic [1:0]  regAddr = 0;
  logic        regWrEn = 0;
  logic [31:0] regWrData = 0;
  logic [31:0] regRdData;
  logic [7:0]  txByte;
  logic        txValid;
  logic        txReady = 0;
  logic        shifterBusy = 0;
  logic [7:0]  rxByte = 0;
  logic        rxValid = 0;
  logic        irqOut;

  int errors = 0;
  int checks = 0;
  logic [7:0] txQ[$];
  logic [7:0] rxQ[$];

  always #5 clk = ~clk;

  serial_host_port i_serial_host_port (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .txByte(txByte),
    .txValid(txValid), .txReady(txReady), .shifterBusy(shifterBusy),
    .rxByte(rxByte), .rxValid(rxValid), .irqOut(irqOut)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Called at a falling edge; returns at the next falling edge.
  task automatic regWrite(input logic [1:0] a, input logic [31:0] d);
    regAddr = a; regWrData = d; regWrEn = 1;
    @(negedge clk);
    regWrEn = 0;
  endtask

  task automatic regRead(input logic [1:0] a, output logic [31:0] d);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic hostSend(input logic [7:0] b);
    if (txQ.size() < 16) txQ.push_back(b);
    regWrite(2'd0, 32'h200 | {24'h0, b});
  endtask

  task automatic lineSend(input logic [7:0] b);
    if (rxQ.size() < 16) rxQ.push_back(b);
    rxByte = b; rxValid = 1;
    @(negedge clk);
    rxValid = 0;
  endtask

  task automatic pulseReady();
    txReady = 1;
    @(negedge clk);
    txReady = 0;
  endtask

  task automatic readPopRx(input string req);
    logic [31:0] d;
    logic [7:0]  e;
    regRead(2'd0, d);
    e = (rxQ.size() != 0) ? rxQ.pop_front() : 8'h00;
    chk(req, {23'h0, d[8:0]}, {23'h0, 1'b1, e});
    regWrite(2'd0, 32'h100);
  endtask

  // Transmit monitor: compares each byte accepted by the serializer with the scoreboard.
  always @(negedge clk) begin
    #2;
    if (rstN && txValid && txReady) begin
      checks++;
      if (txQ.size() == 0) begin
        errors++;
        $display("FAIL R2: actual=%h expected=<none>", txByte);
      end else begin
        logic [7:0] e;
        e = txQ.pop_front();
        if (txByte !== e) begin
          errors++;
          $display("FAIL R2: actual=%h expected=%h", txByte, e);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rstN = 1;

    // R1 reset state
    regRead(2'd0, d); chk("R1 data", d, 32'h200);
    regRead(2'd1, d); chk("R1 ctrl", d, 32'h0);
    regRead(2'd2, d); chk("R1 status", d, 32'h0);
    regRead(2'd3, d); chk("R1 enable", d, 32'h0);
    chk("R1 irq", {31'h0, irqOut}, 32'h0);

    // R2 / R5 ordering and busy
    hostSend(8'hA1); hostSend(8'hB2); hostSend(8'hC3);
    regRead(2'd1, d); chk("R5 busy queued", {31'h0, d[14]}, 32'h1);
    txReady = 1; repeat (5) @(negedge clk); txReady = 0;
    chk("R2 drained", txQ.size(), 0);
    regRead(2'd1, d); chk("R5 idle", {31'h0, d[14]}, 32'h0);
    shifterBusy = 1;
    regRead(2'd1, d); chk("R5 shifter busy", {31'h0, d[14]}, 32'h1);
    shifterBusy = 0;

    // R3 full transmit FIFO
    for (int i = 0; i < 17; i++) hostSend(8'h40 + 8'(i));
    regRead(2'd0, d); chk("R3 flag full", {31'h0, d[9]}, 32'h0);
    txReady = 1; repeat (20) @(negedge clk); txReady = 0;
    chk("R3 extra dropped", txQ.size(), 0);
    regRead(2'd0, d); chk("R3 flag free", {31'h0, d[9]}, 32'h1);

    // R8 almost-empty edge
    regWrite(2'd2, 32'h7);
    for (int i = 0; i < 5; i++) hostSend(8'h90 + 8'(i));
    regRead(2'd2, d); chk("R8 rising no event", {31'h0, d[1]}, 32'h0);
    pulseReady(); pulseReady();
    regRead(2'd2, d); chk("R8 count 3", {31'h0, d[1]}, 32'h0);
    pulseReady();
    regRead(2'd2, d); chk("R8 count 2", {31'h0, d[1]}, 32'h1);
    txReady = 1; repeat (4) @(negedge clk); txReady = 0;

    // R9 receive event, R4 write-one-to-clear
    lineSend(8'h5A);
    regRead(2'd2, d); chk("R9 rx event", d, 32'h3);
    regWrite(2'd2, 32'h1);
    regRead(2'd2, d); chk("R4 clear bit0 only", d, 32'h2);
    regWrite(2'd2, 32'h0);
    regRead(2'd2, d); chk("R4 zero write", d, 32'h2);
    regWrite(2'd2, 32'h2);
    regRead(2'd2, d); chk("R4 clear bit1", d, 32'h0);

    // R9 peek, R10 pop
    regRead(2'd0, d); chk("R9 peek 1", {23'h0, d[8:0]}, {23'h0, 9'h15A});
    regRead(2'd0, d); chk("R9 peek 2", {23'h0, d[8:0]}, {23'h0, 9'h15A});
    readPopRx("R9 head");
    regRead(2'd0, d); chk("R10 empty after pop", {31'h0, d[8]}, 32'h0);
    regWrite(2'd0, 32'h100);
    lineSend(8'h77);
    readPopRx("R10 after empty pop");

    // R7 overflow
    regWrite(2'd2, 32'h7);
    for (int i = 0; i < 17; i++) lineSend(8'hC0 + 8'(i));
    regRead(2'd2, d); chk("R7 overflow bit", {31'h0, d[2]}, 32'h1);
    for (int i = 0; i < 16; i++) readPopRx("R7 order");
    regRead(2'd0, d); chk("R7 extra dropped", {31'h0, d[8]}, 32'h0);

    // R6 interrupt gating
    regWrite(2'd2, 32'h7);
    lineSend(8'h11);
    regWrite(2'd3, 32'h1);
    #1 chk("R6 host off", {31'h0, irqOut}, 32'h0);
    regWrite(2'd1, 32'h2000);
    #1 chk("R6 raised", {31'h0, irqOut}, 32'h1);
    regWrite(2'd3, 32'h2);
    #1 chk("R6 masked", {31'h0, irqOut}, 32'h0);
    regWrite(2'd3, 32'h1);
    regWrite(2'd2, 32'h1);
    #1 chk("R6 acked", {31'h0, irqOut}, 32'h0);
    readPopRx("R9 last");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule